// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a graphics DRAM interface and walks the memory from power-on to a ready state. Once the board reports that supplies and clock are stable, it holds the DRAM reset pin low for a long settle window, then releases it. The level driven on the clock-enable pin at the release edge tells the DRAM which address/command termination strength to use. The block then waits out a second long window while the bus carries only DESELECT.

After the settle windows it issues a fixed command program: precharge all banks, load the extended mode register, load the base mode register with the DLL reset bit set, precharge all banks again, and two auto-refreshes. The gaps between commands come from cycle-count parameters. A DLL lock window runs from the base mode register load, and the ready flag rises only when both the last refresh recovery and the lock window have elapsed. All waits are plain cycle counts. The long ones default to 200 us at a configurable clock frequency, and a bench can override them with short values.

Top module: `gddr_init_seq`

## Requirements
- R1: While reset is held and until `pwr_ok_i` is sampled high, `res_o`=0, `cke_o`=0, `cs_no`=1 and `done_o`=0.
- R2: `res_o` rises exactly PWR_CYC cycles after the clock edge that first samples `pwr_ok_i` high, never falls afterwards, and `cs_no` stays 1 throughout the time `res_o` is low.
- R3: `term_full_i` is captured on the edge that samples `pwr_ok_i` high; `cke_o` equals it (1 = full ZQ termination, 0 = half ZQ) when `res_o` rises and for ATH_CYC cycles, then is 1 for good; later changes of `term_full_i` have no effect.
- R4: From the `res_o` rising cycle, only DESELECT (`cs_no`=1) is driven for ATH_CYC+RES_CYC cycles before the first command.
- R5: Commands, encoded as {`cs_no`,`ras_no`,`cas_no`,`we_no`}, come out in this order: precharge-all 0010 with `addr_o[8]`=1; mode load 0000 with `ba_o`=001 and `addr_o`=EMR_CODE; mode load 0000 with `ba_o`=000 and `addr_o`=MR_CODE with bit 8 (DLL reset) set; precharge-all 0010 with `addr_o[8]`=1; refresh 0001; refresh 0001. Each lasts one cycle.
- R6: Command spacing in cycles is T_RP, T_MRD, T_MRD, T_RP, T_RFC between consecutive commands, with DESELECT in between.
- R7: `done_o` rises exactly one cycle after the later of (second refresh + T_RFC) and (DLL-reset load + DLL_CYC).
- R8: Once `done_o` is 1 it stays 1 and no further command is issued until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supplies and clock stable |
| term_full_i | input | 1 | Requested address/command termination: 1 full ZQ, 0 half ZQ |
| res_o | output | 1 | DRAM reset pin (low = reset) |
| cke_o | output | 1 | DRAM clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank / mode register select |
| addr_o | output | A_W | Address / mode op-code |
| done_o | output | 1 | Initialization complete |

## Verification
The embedded properties assume every timing parameter is at least one cycle and that the block leaves reset with the DRAM pins in their reset state. They place no constraint on `pwr_ok_i` or `term_full_i`. The bench raises `pwr_ok_i` once per run and keeps it high. On the second run it flips `term_full_i` mid-sequence, which leaves the inputs free while showing that the captured value is the one used. The long windows are shortened through parameters so the DLL window dominates the final wait and every gap stays distinct.

// File: rtl/gddr_init_pkg.sv
package gddr_init_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RES_LOW, ST_ATH, ST_RES_WAIT, ST_PRE1, ST_EMR, ST_MR,
    ST_PRE2, ST_REF1, ST_REF2, ST_FINAL, ST_DONE
  } init_st_e;

  typedef enum logic [2:0] {CMD_DESEL, CMD_NOP, CMD_PRE, CMD_MRS, CMD_REF} cmd_e;
endpackage

// File: rtl/init_wait_cnt.sv
module init_wait_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6: a loaded count never reports zero on the following cycle unless it was zero
  a_r6_cnt_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (zero_o == ($past(val_i) == '0)));
endmodule

// File: rtl/init_cmd_enc.sv
module init_cmd_enc
  import gddr_init_pkg::*;
(
  input  cmd_e cmd_i,
  output logic cs_no,
  output logic ras_no,
  output logic cas_no,
  output logic we_no
);
  always_comb begin
    unique case (cmd_i)
      CMD_NOP: {cs_no, ras_no, cas_no, we_no} = 4'b0111;
      CMD_PRE: {cs_no, ras_no, cas_no, we_no} = 4'b0010;
      CMD_MRS: {cs_no, ras_no, cas_no, we_no} = 4'b0000;
      CMD_REF: {cs_no, ras_no, cas_no, we_no} = 4'b0001;
      default: {cs_no, ras_no, cas_no, we_no} = 4'b1111;
    endcase
  end
endmodule

// File: rtl/gddr_init_seq.sv
module gddr_init_seq
  import gddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned WAIT_US = 200,
  parameter int unsigned PWR_CYC = WAIT_US * CLK_MHZ,
  parameter int unsigned RES_CYC = WAIT_US * CLK_MHZ,
  parameter int unsigned ATH_CYC = 4,
  parameter int unsigned DLL_CYC = 5000,
  parameter int unsigned T_RP    = 8,
  parameter int unsigned T_MRD   = 4,
  parameter int unsigned T_RFC   = 32,
  parameter int unsigned BA_W    = 3,
  parameter int unsigned A_W     = 12,
  parameter logic [A_W-1:0] EMR_CODE = '0,
  parameter logic [A_W-1:0] MR_CODE  = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_ok_i,
  input  logic            term_full_i,
  output logic            res_o,
  output logic            cke_o,
  output logic            cs_no,
  output logic            ras_no,
  output logic            cas_no,
  output logic            we_no,
  output logic [BA_W-1:0] ba_o,
  output logic [A_W-1:0]  addr_o,
  output logic            done_o
);
  localparam int unsigned AP_BIT  = 8;  // precharge-all select
  localparam int unsigned DLL_BIT = 8;  // DLL reset in base mode register
  localparam int unsigned M0 = (PWR_CYC > RES_CYC) ? PWR_CYC : RES_CYC;
  localparam int unsigned M1 = (M0 > DLL_CYC) ? M0 : DLL_CYC;
  localparam int unsigned M2 = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int unsigned M3 = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int unsigned M4 = (M3 > ATH_CYC) ? M3 : ATH_CYC;
  localparam int unsigned MAXC = (M2 > M4) ? M2 : M4;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  init_st_e st_q, st_d;
  logic     term_q;
  logic     ld, dll_ld, cnt_zero, dll_zero;
  logic [CNT_W-1:0] ld_val;
  cmd_e     cmd;

  init_wait_cnt #(.W(CNT_W)) u_gap_cnt (
    .clk_i, .rst_ni, .load_i(ld), .val_i(ld_val), .zero_o(cnt_zero));

  init_wait_cnt #(.W(CNT_W)) u_dll_cnt (
    .clk_i, .rst_ni, .load_i(dll_ld), .val_i(CNT_W'(DLL_CYC - 1)), .zero_o(dll_zero));

  init_cmd_enc u_enc (.cmd_i(cmd), .cs_no, .ras_no, .cas_no, .we_no);

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    dll_ld = 1'b0;
    unique case (st_q)
      ST_IDLE:     if (pwr_ok_i) begin st_d = ST_RES_LOW; ld = 1'b1; ld_val = CNT_W'(PWR_CYC - 1); end
      ST_RES_LOW:  if (cnt_zero) begin st_d = ST_ATH;     ld = 1'b1; ld_val = CNT_W'(ATH_CYC - 1); end
      ST_ATH:      if (cnt_zero) begin st_d = ST_RES_WAIT; ld = 1'b1; ld_val = CNT_W'(RES_CYC - 1); end
      ST_RES_WAIT: if (cnt_zero) st_d = ST_PRE1;
      ST_PRE1:     if (cnt_zero) begin st_d = ST_EMR;  ld = 1'b1; ld_val = CNT_W'(T_RP - 1); end
      ST_EMR:      if (cnt_zero) begin st_d = ST_MR;   ld = 1'b1; ld_val = CNT_W'(T_MRD - 1); end
      ST_MR:       if (cnt_zero) begin st_d = ST_PRE2; ld = 1'b1; ld_val = CNT_W'(T_MRD - 1); dll_ld = 1'b1; end
      ST_PRE2:     if (cnt_zero) begin st_d = ST_REF1; ld = 1'b1; ld_val = CNT_W'(T_RP - 1); end
      ST_REF1:     if (cnt_zero) begin st_d = ST_REF2; ld = 1'b1; ld_val = CNT_W'(T_RFC - 1); end
      ST_REF2:     if (cnt_zero) begin st_d = ST_FINAL; ld = 1'b1; ld_val = CNT_W'(T_RFC - 1); end
      ST_FINAL:    if (cnt_zero && dll_zero) st_d = ST_DONE;
      default:     st_d = st_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      term_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && pwr_ok_i) term_q <= term_full_i;
    end
  end

  // command bus: commands fire on the cycle the gap counter reads zero
  always_comb begin
    cmd    = CMD_DESEL;
    ba_o   = '0;
    addr_o = '0;
    if (cnt_zero) begin
      unique case (st_q)
        ST_PRE1, ST_PRE2: begin cmd = CMD_PRE; addr_o[AP_BIT] = 1'b1; end
        ST_EMR:  begin cmd = CMD_MRS; ba_o = BA_W'(1); addr_o = EMR_CODE; end
        ST_MR:   begin cmd = CMD_MRS; addr_o = MR_CODE; addr_o[DLL_BIT] = 1'b1; end
        ST_REF1, ST_REF2: cmd = CMD_REF;
        default: cmd = CMD_DESEL;
      endcase
    end
  end

  assign res_o  = !(st_q inside {ST_IDLE, ST_RES_LOW});
  assign cke_o  = (st_q == ST_IDLE) ? 1'b0 :
                  (st_q inside {ST_RES_LOW, ST_ATH}) ? term_q : 1'b1;
  assign done_o = (st_q == ST_DONE);

  a_r2_cs_high_res_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_o |-> cs_no);
  a_r2_res_no_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o |=> res_o);
  a_r3_cke_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_o) |-> (cke_o == $past(cke_o)));
  a_r4_cmd_needs_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> (cke_o && res_o));
  a_r7_done_after_dll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dll_zero && cnt_zero));
  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && cs_no));
endmodule

// File: tb/tb_gddr_init_seq.sv
`timescale 1ns/1ps
module tb_gddr_init_seq;
  localparam int PWR = 20, RES = 10, ATH = 2, DLL = 40;
  localparam int RP = 3, MRD = 4, RFC = 6;
  localparam logic [11:0] EMR = 12'h02A, MR = 12'h273;

  logic clk = 0, rst_n = 0, pwr_ok = 0, term = 0;
  logic res, cke, cs_n, ras_n, cas_n, we_n, done;
  logic [2:0] ba;
  logic [11:0] addr;
  always #2.5 clk = ~clk;

  gddr_init_seq #(.PWR_CYC(PWR), .RES_CYC(RES), .ATH_CYC(ATH), .DLL_CYC(DLL),
    .T_RP(RP), .T_MRD(MRD), .T_RFC(RFC), .EMR_CODE(EMR), .MR_CODE(MR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .term_full_i(term),
    .res_o(res), .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n),
    .we_no(we_n), .ba_o(ba), .addr_o(addr), .done_o(done));

  int cyc = 0, checks = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // negedge monitor
  bit mon, res_seen, done_seen, cke_rise;
  int t_res, t_done, ncmd, bad_cs, cke_low, post_cmd, done_drop;
  int c_t[8]; logic [2:0] c_code[8]; logic [2:0] c_ba[8]; logic [11:0] c_a[8];

  always @(negedge clk) if (mon) begin
    if (!res && !cs_n) bad_cs++;
    if (res && !res_seen) begin res_seen = 1; t_res = cyc; cke_rise = cke; end
    if (res && !cke) cke_low++;
    if (!cs_n) begin
      if (done_seen) post_cmd++;
      if (ncmd < 8) begin
        c_t[ncmd] = cyc; c_code[ncmd] = {ras_n, cas_n, we_n};
        c_ba[ncmd] = ba; c_a[ncmd] = addr;
      end
      ncmd++;
    end
    if (done_seen && !done) done_drop++;
    if (done && !done_seen) begin done_seen = 1; t_done = cyc; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0d exp=%0d", req, act, exp); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; pwr_ok = 0; mon = 0;
    res_seen = 0; done_seen = 0; ncmd = 0; bad_cs = 0; cke_low = 0;
    post_cmd = 0; done_drop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    do_reset();
    mon = 1;
    repeat (10) @(negedge clk);
    chk(!res, "R1 res", res, 0);
    chk(!cke, "R1 cke", cke, 0);
    chk(cs_n, "R1 cs_n", cs_n, 1);
    chk(!done, "R1 done", done, 0);
    chk(ncmd == 0, "R1 no command", ncmd, 0);
  endtask

  task automatic t_run(input bit term_v, input bit flip);
    int t_go, exp_done, mx;
    logic [2:0] ecode[6];
    int gaps[5];
    ecode = '{3'b010, 3'b000, 3'b000, 3'b010, 3'b001, 3'b001};
    gaps  = '{RP, MRD, MRD, RP, RFC};
    do_reset();
    mon = 1;
    @(negedge clk);
    term = term_v; pwr_ok = 1; t_go = cyc + 1;
    if (flip) begin repeat (3) @(negedge clk); term = !term_v; end
    for (int i = 0; i < 400 && !done_seen; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(t_res - t_go == PWR, "R2 res low window", t_res - t_go, PWR);
    chk(bad_cs == 0, "R2 cs high while res low", bad_cs, 0);
    chk(res, "R2 res stays high", res, 1);
    chk(cke_rise == term_v, "R3 cke at res rise", cke_rise, term_v);
    chk(cke_low == (term_v ? 0 : ATH), "R3 cke low samples", cke_low, term_v ? 0 : ATH);
    chk(cke, "R3 cke high after hold", cke, 1);
    chk(ncmd == 6, "R5 command count", ncmd, 6);
    chk(c_t[0] - t_res == ATH + RES, "R4 deselect window", c_t[0] - t_res, ATH + RES);
    for (int i = 0; i < 6; i++)
      chk(c_code[i] == ecode[i], $sformatf("R5 cmd%0d code", i), c_code[i], ecode[i]);
    chk(c_a[0][8] && c_a[3][8], "R5 precharge-all bit", {c_a[0][8], c_a[3][8]}, 3);
    chk(c_ba[1] == 3'b001 && c_a[1] == EMR, "R5 extended mode load", {c_ba[1], c_a[1]}, {3'b001, EMR});
    chk(c_ba[2] == 3'b000 && c_a[2] == (MR | 12'h100), "R5 mode load dll reset",
        {c_ba[2], c_a[2]}, {3'b000, MR | 12'h100});
    for (int i = 0; i < 5; i++)
      chk(c_t[i+1] - c_t[i] == gaps[i], $sformatf("R6 gap%0d", i), c_t[i+1] - c_t[i], gaps[i]);
    mx = (c_t[5] + RFC > c_t[2] + DLL) ? c_t[5] + RFC : c_t[2] + DLL;
    exp_done = mx + 1;
    chk(done_seen && t_done == exp_done, "R7 done timing", t_done, exp_done);
    chk(t_done - c_t[2] > DLL, "R7 dll window", t_done - c_t[2], DLL + 1);
    chk(done_drop == 0 && done, "R8 done sticky", done_drop, 0);
    chk(post_cmd == 0, "R8 no command after done", post_cmd, 0);
  endtask

  initial begin
    t_reset_state();
    t_run(1'b0, 1'b0);
    t_run(1'b1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule